// File: doc/BRIEF.md
# SMBus Block-Write Configuration Slave

This block is the serial configuration port of a clock generator. It listens on a two-wire SMBus (open-drain SDA and SCL, oversampled by a fast system clock) and accepts exactly one kind of transfer: a block write. A block write carries the write address 0xD2, a command code of 0x00, a byte count N, and then N data bytes. The data bytes fill a bank of seven byte-wide control registers, always starting at register 0 and moving upward. The whole register image is presented in parallel, one enable or control bit per clock output, so the clock tree can act on it directly.

A few bits of register 0 are not storage. One bit mirrors a live stop pin. Two bits hold the mode-select straps, which are latched the first time the active-low power-good input is seen low. Every other register bit is either writable or read-only with a fixed value. Transfers that are malformed are refused with a NACK and then ignored until the next start condition. A master may cut a transfer short with a stop after any whole byte.

Top module: `clkcfg_smb_slave`

## Requirements
- R1: After reset the register image reads, from byte 0 to byte 6: 0x01, 0x07, 0x7F, 0xC7, 0x3F, 0x00, 0x06. Byte 0 bit 4 and bits 2:1 are overlays, covered by R10 and R11.
- R2: Only the address byte 0xD2 (7-bit address with R/W=0) is ACKed, meaning SDA is pulled low during the ninth clock. Any other address byte, including the read form 0xD3, is NACKed, and every byte after it is NACKed and stored nowhere until the next start.
- R3: The byte after the address must be 0x00. Any other command byte is NACKed, and no register changes.
- R4: A byte count of 1 to 32 is ACKed. A count of 0 or above 32 is NACKed, and no data byte that follows is stored.
- R5: Data bytes are shifted in MSB first and written to register 0, 1, 2 and so on in arrival order. Each of the first N data bytes is ACKed.
- R6: A stop after any complete byte ends the transfer. Registers already written keep their new values, and later registers keep their old ones.
- R7: Any data byte beyond the first N is NACKed and not stored.
- R8: Data bytes within the count whose index is 7 or higher are ACKed and discarded.
- R9: Writes leave read-only bits unchanged. The writable masks per byte are 0xA8, 0x7F, 0x7F, 0xFF, 0x3F, 0x3F, 0x00. All other stored bits keep their reset values.
- R10: Byte 0 bit 4 always equals the live level of `cpu_halt_n_i`.
- R11: Byte 0 bit 2 holds `strap_i[1]` and bit 1 holds `strap_i[0]`. Both are captured when `pwr_ok_n_i` is first sampled low after reset and read 0 before that. Later changes on the straps or on `pwr_ok_n_i` have no effect.
- R12: A start condition in the middle of a transfer restarts address decoding. The next block write again begins at register 0, and bytes already stored stay.
- R13: Pulses on SCL or SDA that last fewer than FILT_LEN system clocks are ignored. They neither add a bit nor create a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level seen on the SCL wire |
| sda_i | input | 1 | Level seen on the SDA wire |
| sda_pull_o | output | 1 | High to pull SDA low (acknowledge) |
| cpu_halt_n_i | input | 1 | Live active-low stop pin mirrored into byte 0 bit 4 |
| strap_i | input | 2 | Mode straps: bit 1 is S2, bit 0 is S1 |
| pwr_ok_n_i | input | 1 | Active-low power-good strobe that latches the straps |
| cfg_o | output | 56 | Register image, byte k on bits 8k+7:8k |

## Verification
The acknowledge decision and the register write are made in the same cycle, on the SCL falling edge that closes the eighth bit. The bench sweeps byte counts on both sides of the legal range (0, 1, 7, 8, 32, 33 and larger) and sends one more data byte than the count allows. The ACK sampled on the wire must then agree, byte by byte, with the register image compared against an arithmetic model that applies the writable masks. A second collision places a sub-threshold glitch on SCL or SDA inside a data bit. Such a glitch lands in the same cycles as real bit sampling, and it is judged by the stored byte and the ACK coming out exactly as if the glitch were absent.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int         REG_COUNT   = 7;
    localparam int         BLOCK_MAX   = 32;
    localparam logic [7:0] DEV_ADDR_WR = 8'hD2;
    localparam logic [7:0] BLOCK_CMD   = 8'h00;

    // overlay positions inside register byte 0
    localparam int OVL_HALT_BIT = 4;
    localparam int OVL_S2_BIT   = 2;
    localparam int OVL_S1_BIT   = 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } smb_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic scl;
    } bus_evt_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } reg_wr_t;

    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h01;
            1:       return 8'h07;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h3F;
            5:       return 8'h00;
            6:       return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'hA8;
            1:       return 8'h7F;
            2:       return 8'h7F;
            3:       return 8'hFF;
            4:       return 8'h3F;
            5:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_bus_front.sv
module smb_bus_front
    import clkcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [1:0] raw;
    logic [1:0] filt;

    assign raw = {sda_i, scl_i};

    // one conditioner per wire: synchronizer then majority-free run filter
    for (genvar l = 0; l < 2; l++) begin : g_line
        logic [SYNC_STAGES-1:0] sync_q;
        logic [FILT_LEN-1:0]    hist_q;
        logic                   out_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '1;
                hist_q <= '1;
                out_q  <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], raw[l]};
                hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
                if (&hist_q) begin
                    out_q <= 1'b1;
                end else if (~|hist_q) begin
                    out_q <= 1'b0;
                end
            end
        end

        assign filt[l] = out_q;
    end

    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= filt[0];
            sda_prev_q <= filt[1];
        end
    end

    always_comb begin
        evt_o.scl      = filt[0];
        evt_o.sda      = filt[1];
        evt_o.scl_rise = filt[0] & ~scl_prev_q;
        evt_o.scl_fall = ~filt[0] & scl_prev_q;
        evt_o.start    = filt[0] & scl_prev_q & sda_prev_q & ~filt[1];
        evt_o.stop     = filt[0] & scl_prev_q & ~sda_prev_q & filt[1];
    end

endmodule

// File: rtl/smb_block_fsm.sv
module smb_block_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [7:0] SLAVE_ADDR = DEV_ADDR_WR,
    parameter logic [7:0] CMD_CODE   = BLOCK_CMD,
    parameter int         MAX_COUNT  = BLOCK_MAX,
    parameter int         NUM_REGS   = REG_COUNT
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt_i,
    output logic       sda_pull_o,
    output reg_wr_t    wr_o,
    output smb_phase_e phase_o
);

    localparam int CNT_W = $clog2(MAX_COUNT + 1);

    smb_phase_e      phase_q;
    smb_phase_e      after_q;
    logic [3:0]      bit_q;
    logic [7:0]      shift_q;
    logic            in_ack_q;
    logic            pull_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] idx_q;
    reg_wr_t         wr_q;

    logic       dec_ack;
    logic       dec_store;
    smb_phase_e dec_next;

    // acknowledge decision for the byte just completed
    always_comb begin
        dec_ack   = 1'b0;
        dec_store = 1'b0;
        dec_next  = PH_IDLE;
        case (phase_q)
            PH_ADDR: begin
                if (shift_q == SLAVE_ADDR) begin
                    dec_ack  = 1'b1;
                    dec_next = PH_CMD;
                end
            end
            PH_CMD: begin
                if (shift_q == CMD_CODE) begin
                    dec_ack  = 1'b1;
                    dec_next = PH_COUNT;
                end
            end
            PH_COUNT: begin
                if (shift_q != 8'd0 && 32'(shift_q) <= MAX_COUNT) begin
                    dec_ack  = 1'b1;
                    dec_next = PH_DATA;
                end
            end
            PH_DATA: begin
                if (left_q != '0) begin
                    dec_ack   = 1'b1;
                    dec_next  = PH_DATA;
                    dec_store = (32'(idx_q) < NUM_REGS);
                end
            end
            default: begin
                dec_ack = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        wr_q.en <= 1'b0;
        if (rst) begin
            phase_q  <= PH_IDLE;
            after_q  <= PH_IDLE;
            bit_q    <= '0;
            shift_q  <= '0;
            in_ack_q <= 1'b0;
            pull_q   <= 1'b0;
            left_q   <= '0;
            idx_q    <= '0;
            wr_q     <= '0;
        end else if (evt_i.start) begin
            phase_q  <= PH_ADDR;
            bit_q    <= '0;
            in_ack_q <= 1'b0;
            pull_q   <= 1'b0;
        end else if (evt_i.stop) begin
            phase_q  <= PH_IDLE;
            bit_q    <= '0;
            in_ack_q <= 1'b0;
            pull_q   <= 1'b0;
        end else if (phase_q != PH_IDLE) begin
            if (evt_i.scl_rise && !in_ack_q && bit_q != 4'd8) begin
                shift_q <= {shift_q[6:0], evt_i.sda};
                bit_q   <= bit_q + 4'd1;
            end
            if (evt_i.scl_fall) begin
                if (in_ack_q) begin
                    in_ack_q <= 1'b0;
                    pull_q   <= 1'b0;
                    bit_q    <= '0;
                    phase_q  <= after_q;
                end else if (bit_q == 4'd8) begin
                    in_ack_q <= 1'b1;
                    pull_q   <= dec_ack;
                    after_q  <= dec_next;
                    if (phase_q == PH_COUNT && dec_ack) begin
                        left_q <= CNT_W'(shift_q);
                        idx_q  <= '0;
                    end
                    if (phase_q == PH_DATA && dec_ack) begin
                        left_q <= left_q - 1'b1;
                        if (dec_store) begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    if (dec_store) begin
                        wr_q.en   <= 1'b1;
                        wr_q.idx  <= 8'(idx_q);
                        wr_q.data <= shift_q;
                    end
                end
            end
        end
    end

    assign sda_pull_o = pull_q;
    assign wr_o       = wr_q;
    assign phase_o    = phase_q;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = REG_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  reg_wr_t               wr_i,
    output logic [NUM_REGS*8-1:0] img_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        localparam logic [7:0] RST_VAL = reg_reset(g);
        localparam logic [7:0] WMASK   = reg_wmask(g);
        logic [7:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= RST_VAL;
            end else if (wr_i.en && wr_i.idx == 8'(g)) begin
                byte_q <= (byte_q & ~WMASK) | (wr_i.data & WMASK);
            end
        end

        assign img_o[g*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/smb_strap_latch.sv
module smb_strap_latch #(
    parameter int STRAP_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_ok_n_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [STRAP_W-1:0] strap_o,
    output logic               done_o
);

    logic [1:0]         sync_q;
    logic [STRAP_W-1:0] strap_q;
    logic               done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            strap_q <= '0;
            done_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pwr_ok_n_i};
            if (!done_q && !sync_q[1]) begin
                strap_q <= strap_i;
                done_q  <= 1'b1;
            end
        end
    end

    assign strap_o = strap_q;
    assign done_o  = done_q;

endmodule

// File: rtl/clkcfg_smb_slave.sv
module clkcfg_smb_slave
    import clkcfg_pkg::*;
#(
    parameter int         NUM_REGS    = REG_COUNT,
    parameter int         MAX_COUNT   = BLOCK_MAX,
    parameter logic [7:0] SLAVE_ADDR  = DEV_ADDR_WR,
    parameter logic [7:0] CMD_CODE    = BLOCK_CMD,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    input  logic                  cpu_halt_n_i,
    input  logic [1:0]            strap_i,
    input  logic                  pwr_ok_n_i,
    output logic [NUM_REGS*8-1:0] cfg_o
);

    bus_evt_t              bus_evt;
    reg_wr_t               reg_wr;
    smb_phase_e            fsm_phase;
    logic [NUM_REGS*8-1:0] stored_img;
    logic [1:0]            strap_q;
    logic                  strap_done;

    smb_bus_front #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_front (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .evt_o(bus_evt)
    );

    smb_block_fsm #(
        .SLAVE_ADDR(SLAVE_ADDR),
        .CMD_CODE  (CMD_CODE),
        .MAX_COUNT (MAX_COUNT),
        .NUM_REGS  (NUM_REGS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (bus_evt),
        .sda_pull_o(sda_pull_o),
        .wr_o      (reg_wr),
        .phase_o   (fsm_phase)
    );

    smb_reg_bank #(
        .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr_i (reg_wr),
        .img_o(stored_img)
    );

    smb_strap_latch #(
        .STRAP_W(2)
    ) u_strap (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok_n_i(pwr_ok_n_i),
        .strap_i   (strap_i),
        .strap_o   (strap_q),
        .done_o    (strap_done)
    );

    always_comb begin
        cfg_o               = stored_img;
        cfg_o[OVL_HALT_BIT] = cpu_halt_n_i;
        cfg_o[OVL_S2_BIT]   = strap_q[1];
        cfg_o[OVL_S1_BIT]   = strap_q[0];
    end

endmodule

// File: rtl/clkcfg_smb_checker.sv
module clkcfg_smb_checker
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = REG_COUNT
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sda_pull,
    input bus_evt_t              evt,
    input smb_phase_e            phase,
    input logic [NUM_REGS*8-1:0] stored,
    input logic                  strap_done,
    input logic [1:0]            cfg_straps
);

    function automatic logic [NUM_REGS*8-1:0] ro_bits();
        logic [NUM_REGS*8-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            m[i*8 +: 8] = ~reg_wmask(i);
        end
        return m;
    endfunction

    localparam logic [NUM_REGS*8-1:0] RO_MASK = ro_bits();

    // acknowledge is only driven while SCL is low (R5)
    assert_ack_low_scl_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !evt.scl);

    // an idle or refused slave leaves SDA alone (R2)
    assert_idle_release_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_pull);

    // read-only stored bits never move (R9)
    assert_ro_stable_R9: assert property (@(posedge clk) disable iff (rst)
        $stable(stored & RO_MASK));

    // straps frozen once captured (R11)
    assert_strap_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        $past(strap_done) |-> $stable(cfg_straps));

    // a register only changes inside an acknowledged byte slot (R7)
    assert_store_on_ack_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(stored) |-> (sda_pull && $past(sda_pull)));

endmodule

bind clkcfg_smb_slave clkcfg_smb_checker #(
    .NUM_REGS(NUM_REGS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_pull  (sda_pull_o),
    .evt       (bus_evt),
    .phase     (fsm_phase),
    .stored    (stored_img),
    .strap_done(strap_done),
    .cfg_straps({cfg_o[2], cfg_o[1]})
);

// File: tb/clkcfg_smb_slave_test.sv
module clkcfg_smb_slave_test;

    localparam int Q = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic        cpu_halt_n = 1'b1;
    logic [1:0]  straps = 2'b10;
    logic        pwr_ok_n = 1'b1;
    logic [55:0] cfg;
    logic        sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #5 clk = ~clk;

    clkcfg_smb_slave uut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .cpu_halt_n_i(cpu_halt_n),
        .strap_i     (straps),
        .pwr_ok_n_i  (pwr_ok_n),
        .cfg_o       (cfg)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] exp_b [7];
    logic [7:0] wmask [7] = '{8'hA8, 8'h7F, 8'h7F, 8'hFF, 8'h3F, 8'h3F, 8'h00};
    logic [7:0] dflt  [7] = '{8'h01, 8'h07, 8'h7F, 8'hC7, 8'h3F, 8'h00, 8'h06};
    logic [1:0] strap_exp = 2'b00;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int k);
        logic [7:0] v;
        v = exp_b[k];
        if (k == 0) begin
            v[4] = cpu_halt_n;
            v[2] = strap_exp[1];
            v[1] = strap_exp[0];
        end
        return v;
    endfunction

    task automatic chk_image(input string tag);
        for (int k = 0; k < 7; k++) begin
            chk(cfg[k*8 +: 8] == exp_byte(k), tag, 32'(cfg[k*8 +: 8]), 32'(exp_byte(k)));
        end
    endtask

    task automatic model_write(input int k, input logic [7:0] d);
        if (k < 7) exp_b[k] = (exp_b[k] & ~wmask[k]) | (d & wmask[k]);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(3);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(3);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    // glitch: 0 none, 1 short SCL pulse while low, 2 short SDA flip while SCL high
    task automatic send_byte(input logic [7:0] b, input int glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch == 1 && i == 4) begin
                tick(4); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q - 6);
            end else begin
                tick(Q);
            end
            scl_m = 1'b1;
            if (glitch == 2 && i == 3) begin
                tick(4); sda_m = ~b[i]; tick(2); sda_m = b[i]; tick(Q - 6);
            end else begin
                tick(Q);
            end
            scl_m = 1'b0; tick(3);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        ack = ~sda_line;
        tick(Q / 2);
        scl_m = 1'b0; tick(3);
    endtask

    task automatic head(input logic [7:0] cnt, input string tag, input bit cnt_ok);
        bit a;
        bus_start();
        send_byte(8'hD2, 0, a); chk(a == 1'b1, {tag, " R2 addr ack"}, 32'(a), 1);
        send_byte(8'h00, 0, a); chk(a == 1'b1, {tag, " R3 cmd ack"}, 32'(a), 1);
        send_byte(cnt, 0, a);   chk(a == cnt_ok, {tag, " R4 count ack"}, 32'(a), 32'(cnt_ok));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a;
        int cnts [9] = '{0, 1, 3, 7, 8, 12, 32, 33, 200};
        for (int k = 0; k < 7; k++) exp_b[k] = dflt[k];
        tick(6);
        rst = 1'b0;
        tick(4);

        // R1 reset image, straps not yet captured
        chk_image("R1 reset image");
        chk(cfg[2:1] == 2'b00, "R11 straps before power-good", 32'(cfg[2:1]), 0);

        // R11 capture then freeze
        pwr_ok_n = 1'b0; tick(10);
        strap_exp = 2'b10;
        chk(cfg[2:1] == 2'b10, "R11 strap capture", 32'(cfg[2:1]), 2);
        straps = 2'b01; pwr_ok_n = 1'b1; tick(10); pwr_ok_n = 1'b0; tick(10);
        chk(cfg[2:1] == 2'b10, "R11 strap frozen", 32'(cfg[2:1]), 2);

        // R10 live mirror
        cpu_halt_n = 1'b0; tick(1);
        chk(cfg[4] == 1'b0, "R10 halt low", 32'(cfg[4]), 0);
        cpu_halt_n = 1'b1; tick(1);
        chk(cfg[4] == 1'b1, "R10 halt high", 32'(cfg[4]), 1);

        // R9 all ones then all zeros into every register
        for (int pass = 0; pass < 2; pass++) begin
            logic [7:0] v;
            v = (pass == 0) ? 8'hFF : 8'h00;
            head(8'd7, "R9", 1'b1);
            for (int i = 0; i < 7; i++) begin
                send_byte(v, 0, a);
                chk(a == 1'b1, "R5 data ack", 32'(a), 1);
                model_write(i, v);
            end
            bus_stop(); tick(4);
            chk_image("R9 read-only bits");
        end

        // R2 wrong address and read address
        for (int j = 0; j < 2; j++) begin
            logic [7:0] ad;
            ad = (j == 0) ? 8'hD4 : 8'hD3;
            bus_start();
            send_byte(ad, 0, a); chk(a == 1'b0, "R2 foreign addr nack", 32'(a), 0);
            send_byte(8'h00, 0, a); chk(a == 1'b0, "R2 ignored after nack", 32'(a), 0);
            send_byte(8'h01, 0, a); chk(a == 1'b0, "R2 ignored after nack", 32'(a), 0);
            send_byte(8'h55, 0, a); chk(a == 1'b0, "R2 ignored after nack", 32'(a), 0);
            bus_stop(); tick(4);
            chk_image("R2 no change");
        end

        // R3 bad command
        bus_start();
        send_byte(8'hD2, 0, a); chk(a == 1'b1, "R3 addr ack", 32'(a), 1);
        send_byte(8'h01, 0, a); chk(a == 1'b0, "R3 bad cmd nack", 32'(a), 0);
        send_byte(8'h01, 0, a); chk(a == 1'b0, "R3 ignored after nack", 32'(a), 0);
        send_byte(8'hAA, 0, a); chk(a == 1'b0, "R3 ignored after nack", 32'(a), 0);
        bus_stop(); tick(4);
        chk_image("R3 no change");

        // R4 R5 R7 R8 count sweep, one byte past the count
        foreach (cnts[c]) begin
            int  n;
            bit  ok;
            int  nd;
            n  = cnts[c];
            ok = (n >= 1 && n <= 32);
            nd = ok ? n + 1 : 1;
            head(8'(n), "R4 sweep", ok);
            for (int i = 0; i < nd; i++) begin
                logic [7:0] v;
                bit         want;
                v    = 8'(n * 53 + i * 29 + 60);
                want = ok && (i < n);
                send_byte(v, 0, a);
                if (i >= n || !ok)
                    chk(a == want, "R7 byte past count nack", 32'(a), 32'(want));
                else if (i >= 7)
                    chk(a == want, "R8 discarded byte ack", 32'(a), 32'(want));
                else
                    chk(a == want, "R5 data ack", 32'(a), 32'(want));
                if (want) model_write(i, v);
            end
            bus_stop(); tick(4);
            chk_image("R5 sweep image");
        end

        // R6 early stop after two of five bytes
        head(8'd5, "R6", 1'b1);
        send_byte(8'h28, 0, a); model_write(0, 8'h28);
        send_byte(8'h15, 0, a); model_write(1, 8'h15);
        chk(a == 1'b1, "R6 second byte ack", 32'(a), 1);
        bus_stop(); tick(4);
        chk_image("R6 early stop");

        // R12 repeated start mid-transfer
        head(8'd4, "R12", 1'b1);
        send_byte(8'h88, 0, a); model_write(0, 8'h88);
        send_byte(8'h2A, 0, a); model_write(1, 8'h2A);
        head(8'd1, "R12 restart", 1'b1);
        send_byte(8'h20, 0, a); model_write(0, 8'h20);
        chk(a == 1'b1, "R12 first byte again ack", 32'(a), 1);
        send_byte(8'h33, 0, a);
        chk(a == 1'b0, "R12 new count honoured", 32'(a), 0);
        bus_stop(); tick(4);
        chk_image("R12 restart image");

        // R13 short glitches on SCL and SDA inside data bits
        head(8'd2, "R13", 1'b1);
        send_byte(8'hC3, 1, a); model_write(0, 8'hC3);
        chk(a == 1'b1, "R13 scl glitch ack", 32'(a), 1);
        send_byte(8'h5A, 2, a); model_write(1, 8'h5A);
        chk(a == 1'b1, "R13 sda glitch ack", 32'(a), 1);
        bus_stop(); tick(4);
        chk_image("R13 glitch image");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule